// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Wrapping Address Counter

This block is a clocked static RAM of 18-bit words, meant to hold cache line data next to a processor. The address, the write data, the write lane enables and the burst controls are all taken in on the rising clock edge. The output enable is the one input that acts at once, without a clock. A read returns its word one clock after the address was taken in.

A burst starts when either of two start strobes is pulled low. One strobe belongs to the processor and the other to the cache controller, and both load the external address. From then on, a 2-bit counter inside the block supplies the low address bits. The counter steps by one, wrapping modulo 4, in every cycle where the advance input is low. The upper address bits stay fixed for the whole burst. Writes are timed from the clock edge, so no external write pulse is needed. Each 9-bit half of the word has its own lane enable.

The pads are driven from two outputs: a data output and a drive enable. The tri-state buffer sits outside the block. The logical address is 16 bits wide. Storage is indexed by the low `DEPTH_W` address bits, which gives the full 65,536 words when `DEPTH_W` is 16. The default is kept smaller for simulation.

Top module: `sync_burst_sram`

## Requirements
- R1: Reset is synchronous and active-high. It clears the burst base, the burst counter, the read register and the write-in-progress flag. While reset is held with `oe_n` low, `dq_en_o` is 1 and `dq_o` is all zeros.
- R2: Read data for an address taken in at clock edge t appears on `dq_o` after edge t+1. Between edges t and t+1 the output still shows the previous access.
- R3: At a clock edge where `cpu_start_n` or `ctl_start_n` is low (either one alone is enough), the access address becomes `addr_i`.
- R4: When a start strobe and `adv_n` are both low at the same edge, the start strobe wins and the address is loaded from `addr_i`, not incremented.
- R5: At an edge where both start strobes are high and `adv_n` is low, address bits [1:0] increase by one modulo 4 (3 goes to 0) and bits [15:2] are unchanged. `addr_i` is ignored.
- R6: At an edge where both start strobes and `adv_n` are high, the access address repeats unchanged and `addr_i` is ignored.
- R7: `wen_n[0]` low writes `din_i[8:0]` and `wen_n[1]` low writes `din_i[17:9]`, both active-low. A lane whose enable is high keeps its stored bits.
- R8: `oe_n` high drives `dq_en_o` to 0 at once, without waiting for a clock edge. `oe_n` low restores the enable when no write is in progress.
- R9: A write taken in at edge t holds `dq_en_o` at 0 from edge t+1 to edge t+2, even with `oe_n` low.
- R10: A read issued in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registered inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External address, loaded when a burst starts |
| cpu_start_n | input | 1 | Processor-side burst start, active-low |
| ctl_start_n | input | 1 | Cache-controller-side burst start, active-low |
| adv_n | input | 1 | Burst advance, active-low |
| wen_n | input | LANES | Lane write enables, active-low; bit 0 is the lower 9 bits |
| din_i | input | LANE_W*LANES | Write data |
| oe_n | input | 1 | Asynchronous output enable, active-low |
| dq_o | output | LANE_W*LANES | Registered read data |
| dq_en_o | output | 1 | Pad drive enable; 0 means the data pins are released |

## Verification
The bench runs bursts that start at low bits 2, so the counter must wrap from 3 to 0. A design that carried into bit 2 instead would return words from the neighbouring line. It asserts a start strobe together with advance from a nonzero counter state, which catches an advance that wins over the start or an address that lands one past the loaded one. It writes one lane at a time and then reads the word back at once. This exposes a lane enable that spills into the other half and a write that lands later than the next read. It also toggles `oe_n` with no clock and checks the output enable during and after writes, which catches an enable that waits for a clock or stays on during a write.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Where the next access address comes from
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_STEP = 2'd2
  } addr_src_e;

  // A start strobe outranks the advance input
  function automatic addr_src_e pick_src(input logic start_any, input logic adv);
    if (start_any)  return SRC_LOAD;
    else if (adv)   return SRC_STEP;
    else            return SRC_HOLD;
  endfunction

endpackage

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_any,
  input  logic              adv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int BASE_W = ADDR_W - BURST_W;

  logic [BASE_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  addr_src_e          src;

  assign src = pick_src(start_any, adv);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (src)
        SRC_LOAD: begin
          base_q <= ext_addr[ADDR_W-1:BURST_W];
          cnt_q  <= ext_addr[BURST_W-1:0];
        end
        SRC_STEP: cnt_q <= cnt_q + BURST_W'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign acc_addr = {base_q, cnt_q};

endmodule

// File: rtl/sbs_in_reg.sv
module sbs_in_reg #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        wen_n,
  input  logic [LANE_W*LANES-1:0] din,
  output logic [LANES-1:0]        wen_q,
  output logic [LANE_W*LANES-1:0] din_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q <= '0;
      din_q <= '0;
    end else begin
      wen_q <= ~wen_n;
      din_q <= din;
    end
  end

endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int W  = 9,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Write port: one lane of the word
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  // Registered read, read-before-write on a shared address
  always_ff @(posedge clk) begin
    if (rst) rd <= '0;
    else     rd <= mem[addr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH_W = 10,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cpu_start_n,
  input  logic                    ctl_start_n,
  input  logic                    adv_n,
  input  logic [LANES-1:0]        wen_n,
  input  logic [LANE_W*LANES-1:0] din_i,
  input  logic                    oe_n,
  output logic [LANE_W*LANES-1:0] dq_o,
  output logic                    dq_en_o
);

  localparam int DATA_W = LANE_W * LANES;

  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  wen_q;
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] rd_word;
  logic              out_wr_q;

  sbs_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .start_any (~cpu_start_n | ~ctl_start_n),
    .adv       (~adv_n),
    .ext_addr  (addr_i),
    .acc_addr  (acc_addr)
  );

  sbs_in_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_inreg (
    .clk   (clk),
    .rst   (rst),
    .wen_n (wen_n),
    .din   (din_i),
    .wen_q (wen_q),
    .din_q (din_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_ram #(.W(LANE_W), .AW(DEPTH_W)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (wen_q[g]),
      .addr (acc_addr[DEPTH_W-1:0]),
      .wd   (din_q[g*LANE_W +: LANE_W]),
      .rd   (rd_word[g*LANE_W +: LANE_W])
    );
  end

  // Marks the output slot that belongs to a write cycle
  always_ff @(posedge clk) begin
    if (rst) out_wr_q <= 1'b0;
    else     out_wr_q <= |wen_q;
  end

  assign dq_o    = rd_word;
  assign dq_en_o = ~oe_n & ~out_wr_q;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2,
  parameter int LANES   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cpu_start_n,
  input logic              ctl_start_n,
  input logic              adv_n,
  input logic [LANES-1:0]  wen_n,
  input logic              oe_n,
  input logic              dq_en_o,
  input logic [ADDR_W-1:0] acc_addr
);

  logic start_any;
  assign start_any = ~cpu_start_n | ~ctl_start_n;

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> acc_addr == '0);

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_any |=> acc_addr == $past(addr_i));

  // R4
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start_any && !adv_n) |=> acc_addr == $past(addr_i));

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_any && !adv_n) |=>
      (acc_addr[BURST_W-1:0] == BURST_W'($past(acc_addr[BURST_W-1:0]) + BURST_W'(1))) &&
      (acc_addr[ADDR_W-1:BURST_W] == $past(acc_addr[ADDR_W-1:BURST_W])));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_any && adv_n) |=> $stable(acc_addr));

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_en_o);

  // R9
  wr_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wen_n != '1) |-> ##2 !dq_en_o);

endmodule

bind sync_burst_sram sbs_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .adv_n       (adv_n),
  .wen_n       (wen_n),
  .oe_n        (oe_n),
  .dq_en_o     (dq_en_o),
  .acc_addr    (acc_addr)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
  logic [1:0]  wen_n = 2'b11;
  logic [17:0] din = '0;
  logic [17:0] dq;
  logic        dq_en;

  int n_run = 0;
  int n_fail = 0;
  logic [17:0] model [0:1023];

  always #2 clk = ~clk;

  sync_burst_sram dut (
    .clk(clk), .rst(rst), .addr_i(addr), .cpu_start_n(cpu_n), .ctl_start_n(ctl_n),
    .adv_n(adv_n), .wen_n(wen_n), .din_i(din), .oe_n(oe_n), .dq_o(dq), .dq_en_o(dq_en)
  );

  function automatic logic [17:0] pat(input logic [15:0] a);
    return {a[8:0] ^ 9'h155, a[8:0] + 9'h0A3};
  endfunction

  task automatic drive(input logic [15:0] a, input logic c, input logic t,
                       input logic v, input logic [1:0] w, input logic [17:0] d);
    addr = a; cpu_n = c; ctl_n = t; adv_n = v; wen_n = w; din = d;
  endtask

  task automatic idle();
    drive(16'h3FF, 1'b1, 1'b1, 1'b1, 2'b11, 18'h0);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); oe_n = 1'b0;
    tick(); tick();
    chk(dq_en == 1'b1 && dq == 18'h0, "R1 reset output", {dq_en, dq[16:0]}, 18'h20000);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int b = 0; b < 2; b++) begin
      logic [15:0] base = (b == 0) ? 16'h40 : 16'h44;
      drive(base, b != 0, b == 0, 1'b1, 2'b00, pat(base));
      model[base[9:0]] = pat(base);
      tick();
      for (int k = 1; k < 4; k++) begin
        logic [15:0] a = base + 16'(k);
        drive(16'h3FF, 1'b1, 1'b1, 1'b0, 2'b00, pat(a));
        model[a[9:0]] = pat(a);
        tick();
        chk(dq_en == 1'b0, "R9 released during write", {17'h0, dq_en}, 18'h0);
      end
    end
    idle(); tick();
    chk(dq_en == 1'b0, "R9 released after last write", {17'h0, dq_en}, 18'h0);
    tick();
    chk(dq_en == 1'b1, "R9 drive back after write", {17'h0, dq_en}, 18'h1);
  endtask

  task automatic t_wrap();
    logic [15:0] seq [5] = '{16'h42, 16'h43, 16'h40, 16'h41, 16'h42};
    drive(16'h42, 1'b1, 1'b0, 1'b1, 2'b11, 18'h0);
    tick();
    for (int i = 0; i < 4; i++) begin
      drive(16'h3FC, 1'b1, 1'b1, 1'b0, 2'b11, 18'h0);
      tick();
      chk(dq == model[seq[i][9:0]], "R3/R5 burst wrap word", dq, model[seq[i][9:0]]);
    end
    idle(); tick();
    chk(dq == model[seq[4][9:0]], "R5 wrap back to start", dq, model[seq[4][9:0]]);
  endtask

  task automatic t_hold();
    drive(16'h45, 1'b0, 1'b1, 1'b1, 2'b11, 18'h0);
    tick();
    drive(16'h41, 1'b1, 1'b1, 1'b1, 2'b11, 18'h0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(dq == model[16'h45], "R6 address held", dq, model[16'h45]);
    end
  endtask

  task automatic t_prio();
    drive(16'h44, 1'b0, 1'b1, 1'b0, 2'b11, 18'h0);
    tick();
    idle(); tick();
    chk(dq == model[16'h44], "R4 start beats advance", dq, model[16'h44]);
    drive(16'h3FF, 1'b1, 1'b1, 1'b0, 2'b11, 18'h0);
    tick();
    chk(dq == model[16'h44], "R4 loaded word before step", dq, model[16'h44]);
    idle(); tick();
    chk(dq == model[16'h45], "R5 step after load", dq, model[16'h45]);
  endtask

  task automatic t_lanes();
    logic [17:0] d0 = 18'h2AA55;
    logic [17:0] d1 = 18'h15AA3;
    drive(16'h41, 1'b0, 1'b1, 1'b1, 2'b10, d0);
    model[16'h41] = {model[16'h41][17:9], d0[8:0]};
    tick();
    drive(16'h41, 1'b0, 1'b1, 1'b1, 2'b11, 18'h0);
    tick();
    idle(); tick();
    chk(dq == model[16'h41], "R7/R10 lower lane write", dq, model[16'h41]);
    drive(16'h43, 1'b1, 1'b0, 1'b1, 2'b01, d1);
    model[16'h43] = {d1[17:9], model[16'h43][8:0]};
    tick();
    drive(16'h43, 1'b1, 1'b0, 1'b1, 2'b11, 18'h0);
    tick();
    idle(); tick();
    chk(dq == model[16'h43], "R7/R10 upper lane write", dq, model[16'h43]);
  endtask

  task automatic t_latency();
    drive(16'h40, 1'b0, 1'b1, 1'b1, 2'b11, 18'h0);
    tick();
    chk(dq == model[16'h43], "R2 old word before latency", dq, model[16'h43]);
    drive(16'h47, 1'b0, 1'b1, 1'b1, 2'b11, 18'h0);
    tick();
    chk(dq == model[16'h40], "R2 one clock latency", dq, model[16'h40]);
    idle(); tick();
    chk(dq == model[16'h47], "R2 next word", dq, model[16'h47]);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    chk(dq_en == 1'b0, "R8 async release", {17'h0, dq_en}, 18'h0);
    oe_n = 1'b0; #1;
    chk(dq_en == 1'b1 && dq == model[16'h47], "R8 async drive", dq, model[16'h47]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_wrap();
    t_hold();
    t_prio();
    t_lanes();
    t_latency();
    t_oe();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 18'h1, 18'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule